// File: doc/BRIEF.md
# Prefetch Feedback Monitor

This block gathers the feedback that tells a second-level cache how well its prefetcher is doing. It owns one "brought in by a prefetch" flag per cache block and one per miss-status holding register (MSHR) entry. From event strobes it counts three things: prefetches sent to memory, prefetched blocks that a demand access later uses, and prefetches that a demand access catches while the miss is still outstanding. The tag and data arrays, the MSHR allocator and the prefetch address generator sit outside. They pass in only strobes and indices.

Evictions from the cache mark time. After a programmable number of them the interval closes. Each long-run counter becomes the average of its old value and the count just gathered. The averaged counts are then published together with an accuracy class (high, medium or low) and a lateness class (late or not late), both taken against programmable percentage thresholds. The classifier cross-multiplies instead of dividing.

Top module: `pf_feedback_mon`

## Requirements
- R1: While and right after reset, `rpt_vld` is 0, all reported counts are 0, `rpt_acc_class` is 2'b00 and `rpt_late_cls` is 0. Every block flag and every MSHR flag is clear.
- R2: Each cycle with `pf_issue` high adds one to the interval's prefetch total.
- R3: A demand hit (`hit_vld`) on a block whose flag is set adds one to the interval's used count and clears that flag. A hit on a block whose flag is clear changes no count. A prefetched block is therefore counted as used at most once per fill.
- R4: A fill with `fill_is_pf`=1 sets the flag of `fill_idx`. A fill with `fill_is_pf`=0 (a demand fill) clears it.
- R5: An MSHR allocation sets that entry's flag to `mshr_alloc_pf`, and a free clears it. A demand merge (`mshr_merge_vld`) into an entry whose flag is set adds one to the interval's late count and clears the flag. A merge into an entry whose flag is clear adds nothing.
- R6: Every `evict_vld` cycle counts one eviction. The eviction that brings the count to `cfg_interval` closes the interval; a value of 0 acts as 1. `rpt_vld` is high for exactly the one cycle after that strobe. Events in the closing cycle belong to the closing interval. The interval counts and the eviction count then restart from zero.
- R7: When an interval closes, each reported count becomes floor((previous reported value + interval count) / 2). The previous reported value is 0 after reset.
- R8: `rpt_acc_class` is 2'b10 (high) when used×100 ≥ `cfg_acc_hi`×total. Otherwise it is 2'b01 (medium) when used×100 ≥ `cfg_acc_lo`×total. Otherwise it is 2'b00 (low). The comparison uses the newly reported values and the thresholds present in the closing cycle, so a total of 0 gives high. The value 2'b11 never appears.
- R9: `rpt_late_cls` is 1 when late×100 ≥ `cfg_late_thr`×used, using the newly reported values and the threshold present in the closing cycle.
- R10: Interval counts saturate at 0xFFFF and never wrap.
- R11: All reported counts and classes hold their values between `rpt_vld` pulses.
- R12: When events collide on one flag in one cycle, the demand test sees the flag value from before that cycle. A fill or allocation write in the same cycle wins over the clear that the test would cause. An MSHR free wins over the merge's clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_issue | input | 1 | A prefetch was sent to memory |
| fill_vld | input | 1 | A block is being filled |
| fill_idx | input | $clog2(NUM_BLOCKS) | Index of the filled block |
| fill_is_pf | input | 1 | The fill came from a prefetch |
| hit_vld | input | 1 | A demand access hit the tag store |
| hit_idx | input | $clog2(NUM_BLOCKS) | Index of the hit block |
| mshr_alloc_vld | input | 1 | An MSHR entry is allocated |
| mshr_alloc_idx | input | $clog2(NUM_MSHR) | Allocated entry |
| mshr_alloc_pf | input | 1 | The allocation is for a prefetch |
| mshr_free_vld | input | 1 | An MSHR entry retires |
| mshr_free_idx | input | $clog2(NUM_MSHR) | Retiring entry |
| mshr_merge_vld | input | 1 | A demand access merged into an outstanding entry |
| mshr_merge_idx | input | $clog2(NUM_MSHR) | Entry merged into |
| evict_vld | input | 1 | A block was evicted from the cache |
| cfg_interval | input | EVC_W | Evictions per interval (0 acts as 1) |
| cfg_acc_hi | input | THR_W | High-accuracy threshold, percent |
| cfg_acc_lo | input | THR_W | Low-accuracy threshold, percent |
| cfg_late_thr | input | THR_W | Lateness threshold, percent |
| rpt_vld | output | 1 | One-cycle pulse: a new report is out |
| rpt_total | output | CNT_W | Averaged prefetch total |
| rpt_used | output | CNT_W | Averaged used count |
| rpt_late | output | CNT_W | Averaged late count |
| rpt_acc_class | output | 2 | 10 high, 01 medium, 00 low |
| rpt_late_cls | output | 1 | 1 when late |

## Verification
A flag bit left set or cleared by mistake does not show at the ports when it happens. It only shifts the used or late count, and that count becomes visible at the next report pulse, up to a full interval of evictions later. Short intervals and a narrow range of indices make flag collisions and re-touches frequent, so such an error reaches the outputs within a few dozen cycles. A wrong eviction count shows as a report pulse in the wrong cycle, and a wrong average or class shows in the pulse cycle itself. Because the reported values hold between pulses, any drift is caught on the very next clock.

// File: rtl/pf_feedback_pkg.sv
package pf_feedback_pkg;

    typedef enum logic [1:0] {
        ACC_LOW  = 2'b00,
        ACC_MED  = 2'b01,
        ACC_HIGH = 2'b10
    } acc_class_e;

endpackage

// File: rtl/pf_flag_bank.sv
// One flag bit per slot: a test port that reads and clears, a clear port and a write port.
module pf_flag_bank #(
    parameter int DEPTH = 128,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tst_vld,
    input  logic [IW-1:0] tst_idx,
    output logic          tst_hit,
    input  logic          clr_vld,
    input  logic [IW-1:0] clr_idx,
    input  logic          wr_vld,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_val
);
    logic [DEPTH-1:0] flags_d, flags_q;

    always_comb begin
        tst_hit = tst_vld & flags_q[tst_idx];
        flags_d = flags_q;
        if (tst_hit) flags_d[tst_idx] = 1'b0;
        if (clr_vld) flags_d[clr_idx] = 1'b0;
        if (wr_vld)  flags_d[wr_idx]  = wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/pf_ratio_classify.sv
// Divider-free percentage classification by cross multiplication.
module pf_ratio_classify
    import pf_feedback_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int THR_W = 7
) (
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] used,
    input  logic [CNT_W-1:0] late,
    input  logic [THR_W-1:0] acc_hi,
    input  logic [THR_W-1:0] acc_lo,
    input  logic [THR_W-1:0] late_thr,
    output acc_class_e       acc_cls,
    output logic             is_late
);
    localparam int MW = (THR_W > 7) ? THR_W : 7;
    localparam int PW = CNT_W + MW;

    logic [PW-1:0] used_pct, late_pct, hi_lim, lo_lim, late_lim;

    always_comb begin
        used_pct = PW'(used) * PW'(100);
        late_pct = PW'(late) * PW'(100);
        hi_lim   = PW'(acc_hi) * PW'(total);
        lo_lim   = PW'(acc_lo) * PW'(total);
        late_lim = PW'(late_thr) * PW'(used);
        if (used_pct >= hi_lim)      acc_cls = ACC_HIGH;
        else if (used_pct >= lo_lim) acc_cls = ACC_MED;
        else                         acc_cls = ACC_LOW;
        is_late = (late_pct >= late_lim);
    end
endmodule

// File: rtl/pf_feedback_mon.sv
module pf_feedback_mon
    import pf_feedback_pkg::*;
#(
    parameter int NUM_BLOCKS = 2048,
    parameter int NUM_MSHR   = 128,
    parameter int CNT_W      = 16,
    parameter int THR_W      = 7,
    parameter int EVC_W      = 16,
    localparam int BIW = $clog2(NUM_BLOCKS),
    localparam int MIW = $clog2(NUM_MSHR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pf_issue,
    input  logic             fill_vld,
    input  logic [BIW-1:0]   fill_idx,
    input  logic             fill_is_pf,
    input  logic             hit_vld,
    input  logic [BIW-1:0]   hit_idx,
    input  logic             mshr_alloc_vld,
    input  logic [MIW-1:0]   mshr_alloc_idx,
    input  logic             mshr_alloc_pf,
    input  logic             mshr_free_vld,
    input  logic [MIW-1:0]   mshr_free_idx,
    input  logic             mshr_merge_vld,
    input  logic [MIW-1:0]   mshr_merge_idx,
    input  logic             evict_vld,
    input  logic [EVC_W-1:0] cfg_interval,
    input  logic [THR_W-1:0] cfg_acc_hi,
    input  logic [THR_W-1:0] cfg_acc_lo,
    input  logic [THR_W-1:0] cfg_late_thr,
    output logic             rpt_vld,
    output logic [CNT_W-1:0] rpt_total,
    output logic [CNT_W-1:0] rpt_used,
    output logic [CNT_W-1:0] rpt_late,
    output logic [1:0]       rpt_acc_class,
    output logic             rpt_late_cls
);
    typedef struct packed {
        logic [EVC_W-1:0] evc;
        logic [CNT_W-1:0] cur_tot;
        logic [CNT_W-1:0] cur_use;
        logic [CNT_W-1:0] cur_late;
        logic [CNT_W-1:0] avg_tot;
        logic [CNT_W-1:0] avg_use;
        logic [CNT_W-1:0] avg_late;
        logic             rpt;
        acc_class_e       acc;
        logic             late_cls;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic             used_ev, late_ev, int_end;
    logic [CNT_W-1:0] nxt_tot, nxt_use, nxt_late;
    logic [CNT_W-1:0] new_tot, new_use, new_late;
    logic [EVC_W-1:0] len_eff;
    acc_class_e       cls_acc;
    logic             cls_late;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v, input logic inc);
        return (inc && (v != '1)) ? v + 1'b1 : v;
    endfunction

    function automatic logic [CNT_W-1:0] half_sum(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CNT_W:1];
    endfunction

    // Block flags: demand hit tests and clears, fills write.
    pf_flag_bank #(.DEPTH(NUM_BLOCKS)) blk_flags_i (
        .clk(clk), .rst_n(rst_n),
        .tst_vld(hit_vld), .tst_idx(hit_idx), .tst_hit(used_ev),
        .clr_vld(1'b0), .clr_idx('0),
        .wr_vld(fill_vld), .wr_idx(fill_idx), .wr_val(fill_is_pf)
    );

    // MSHR flags: demand merge tests and clears, free clears, allocation writes.
    pf_flag_bank #(.DEPTH(NUM_MSHR)) mshr_flags_i (
        .clk(clk), .rst_n(rst_n),
        .tst_vld(mshr_merge_vld), .tst_idx(mshr_merge_idx), .tst_hit(late_ev),
        .clr_vld(mshr_free_vld), .clr_idx(mshr_free_idx),
        .wr_vld(mshr_alloc_vld), .wr_idx(mshr_alloc_idx), .wr_val(mshr_alloc_pf)
    );

    always_comb begin
        nxt_tot  = sat_inc(st_q.cur_tot, pf_issue);
        nxt_use  = sat_inc(st_q.cur_use, used_ev);
        nxt_late = sat_inc(st_q.cur_late, late_ev);
        new_tot  = half_sum(st_q.avg_tot, nxt_tot);
        new_use  = half_sum(st_q.avg_use, nxt_use);
        new_late = half_sum(st_q.avg_late, nxt_late);
        len_eff  = (cfg_interval == '0) ? EVC_W'(1) : cfg_interval;
        int_end  = evict_vld && ({1'b0, st_q.evc} + 1'b1 >= {1'b0, len_eff});
    end

    pf_ratio_classify #(.CNT_W(CNT_W), .THR_W(THR_W)) classify_i (
        .total(new_tot), .used(new_use), .late(new_late),
        .acc_hi(cfg_acc_hi), .acc_lo(cfg_acc_lo), .late_thr(cfg_late_thr),
        .acc_cls(cls_acc), .is_late(cls_late)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rpt = 1'b0;
        if (int_end) begin
            st_d.avg_tot  = new_tot;
            st_d.avg_use  = new_use;
            st_d.avg_late = new_late;
            st_d.acc      = cls_acc;
            st_d.late_cls = cls_late;
            st_d.rpt      = 1'b1;
            st_d.cur_tot  = '0;
            st_d.cur_use  = '0;
            st_d.cur_late = '0;
            st_d.evc      = '0;
        end else begin
            st_d.cur_tot  = nxt_tot;
            st_d.cur_use  = nxt_use;
            st_d.cur_late = nxt_late;
            if (evict_vld) st_d.evc = st_q.evc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{acc: ACC_LOW, default: '0};
        else        st_q <= st_d;
    end

    assign rpt_vld       = st_q.rpt;
    assign rpt_total     = st_q.avg_tot;
    assign rpt_used      = st_q.avg_use;
    assign rpt_late      = st_q.avg_late;
    assign rpt_acc_class = st_q.acc;
    assign rpt_late_cls  = st_q.late_cls;
endmodule

// File: rtl/pf_feedback_mon_chk.sv
module pf_feedback_mon_chk #(
    parameter int CNT_W = 16,
    parameter int THR_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evict_vld,
    input logic [THR_W-1:0] cfg_acc_hi,
    input logic [THR_W-1:0] cfg_late_thr,
    input logic             rpt_vld,
    input logic [CNT_W-1:0] rpt_total,
    input logic [CNT_W-1:0] rpt_used,
    input logic [CNT_W-1:0] rpt_late,
    input logic [1:0]       rpt_acc_class,
    input logic             rpt_late_cls
);
    localparam int PW = CNT_W + ((THR_W > 7) ? THR_W : 7);

    // R6
    rpt_after_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld |-> $past(evict_vld));

    // R8
    acc_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld |-> (rpt_acc_class != 2'b11));

    // R8
    acc_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_vld && (PW'(rpt_used) * PW'(100) >= PW'($past(cfg_acc_hi)) * PW'(rpt_total)))
        |-> (rpt_acc_class == 2'b10));

    // R9
    late_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld |-> (rpt_late_cls ==
            (PW'(rpt_late) * PW'(100) >= PW'($past(cfg_late_thr)) * PW'(rpt_used))));

    // R11
    rpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_vld |-> ($stable(rpt_total) && $stable(rpt_used) && $stable(rpt_late)
                      && $stable(rpt_acc_class) && $stable(rpt_late_cls)));
endmodule

bind pf_feedback_mon pf_feedback_mon_chk #(.CNT_W(CNT_W), .THR_W(THR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .evict_vld(evict_vld),
    .cfg_acc_hi(cfg_acc_hi), .cfg_late_thr(cfg_late_thr),
    .rpt_vld(rpt_vld), .rpt_total(rpt_total), .rpt_used(rpt_used),
    .rpt_late(rpt_late), .rpt_acc_class(rpt_acc_class), .rpt_late_cls(rpt_late_cls)
);

// File: tb/pf_feedback_mon_tb_top.sv
module pf_feedback_mon_tb_top;
    localparam int NB  = 2048;
    localparam int NM  = 128;
    localparam int BIW = $clog2(NB);
    localparam int MIW = $clog2(NM);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pf_issue, fill_vld, fill_is_pf, hit_vld;
    logic [BIW-1:0] fill_idx, hit_idx;
    logic mshr_alloc_vld, mshr_alloc_pf, mshr_free_vld, mshr_merge_vld;
    logic [MIW-1:0] mshr_alloc_idx, mshr_free_idx, mshr_merge_idx;
    logic evict_vld;
    logic [15:0] cfg_interval;
    logic [6:0]  cfg_acc_hi, cfg_acc_lo, cfg_late_thr;
    logic        rpt_vld, rpt_late_cls;
    logic [15:0] rpt_total, rpt_used, rpt_late;
    logic [1:0]  rpt_acc_class;

    int compared = 0;
    int mismatched = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pf_feedback_mon #(.NUM_BLOCKS(NB), .NUM_MSHR(NM)) dut_i (
        .clk(clk), .rst_n(rst_n), .pf_issue(pf_issue),
        .fill_vld(fill_vld), .fill_idx(fill_idx), .fill_is_pf(fill_is_pf),
        .hit_vld(hit_vld), .hit_idx(hit_idx),
        .mshr_alloc_vld(mshr_alloc_vld), .mshr_alloc_idx(mshr_alloc_idx), .mshr_alloc_pf(mshr_alloc_pf),
        .mshr_free_vld(mshr_free_vld), .mshr_free_idx(mshr_free_idx),
        .mshr_merge_vld(mshr_merge_vld), .mshr_merge_idx(mshr_merge_idx),
        .evict_vld(evict_vld), .cfg_interval(cfg_interval),
        .cfg_acc_hi(cfg_acc_hi), .cfg_acc_lo(cfg_acc_lo), .cfg_late_thr(cfg_late_thr),
        .rpt_vld(rpt_vld), .rpt_total(rpt_total), .rpt_used(rpt_used), .rpt_late(rpt_late),
        .rpt_acc_class(rpt_acc_class), .rpt_late_cls(rpt_late_cls)
    );

    // Behavioural reference model
    bit blk_f [NB];
    bit msh_f [NM];
    int c_tot, c_use, c_late, a_tot, a_use, a_late, m_evc;
    int e_acc;
    bit e_vld, e_lcls;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (blk_f[i]) blk_f[i] = 1'b0;
            foreach (msh_f[i]) msh_f[i] = 1'b0;
            c_tot = 0; c_use = 0; c_late = 0;
            a_tot = 0; a_use = 0; a_late = 0;
            m_evc = 0; e_acc = 0; e_vld = 0; e_lcls = 0;
        end else begin
            bit u, l;
            int nt, nu, nl, len;
            u = hit_vld && blk_f[hit_idx];
            l = mshr_merge_vld && msh_f[mshr_merge_idx];
            if (u) blk_f[hit_idx] = 1'b0;
            if (fill_vld) blk_f[fill_idx] = fill_is_pf;
            if (l) msh_f[mshr_merge_idx] = 1'b0;
            if (mshr_free_vld) msh_f[mshr_free_idx] = 1'b0;
            if (mshr_alloc_vld) msh_f[mshr_alloc_idx] = mshr_alloc_pf;
            nt = (c_tot + int'(pf_issue) > 65535) ? 65535 : c_tot + int'(pf_issue);
            nu = (c_use + int'(u) > 65535) ? 65535 : c_use + int'(u);
            nl = (c_late + int'(l) > 65535) ? 65535 : c_late + int'(l);
            len = (cfg_interval == 0) ? 1 : int'(cfg_interval);
            e_vld = 1'b0;
            if (evict_vld && (m_evc + 1 >= len)) begin
                a_tot = (a_tot + nt) / 2;
                a_use = (a_use + nu) / 2;
                a_late = (a_late + nl) / 2;
                if (a_use * 100 >= int'(cfg_acc_hi) * a_tot)      e_acc = 2;
                else if (a_use * 100 >= int'(cfg_acc_lo) * a_tot) e_acc = 1;
                else                                              e_acc = 0;
                e_lcls = (a_late * 100 >= int'(cfg_late_thr) * a_use);
                c_tot = 0; c_use = 0; c_late = 0; m_evc = 0;
                e_vld = 1'b1;
            end else begin
                c_tot = nt; c_use = nu; c_late = nl;
                if (evict_vld) m_evc = m_evc + 1;
            end
        end
    end

    task automatic cmp(input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            cmp("R6 report strobe", int'(rpt_vld), int'(e_vld));
            cmp("R2/R7/R10/R11 total", int'(rpt_total), a_tot);
            cmp("R3/R4/R12 used", int'(rpt_used), a_use);
            cmp("R5/R12 late", int'(rpt_late), a_late);
            cmp("R8 accuracy class", int'(rpt_acc_class), e_acc);
            cmp("R9 lateness class", int'(rpt_late_cls), int'(e_lcls));
        end
    end

    task automatic clear_inputs();
        pf_issue = 0; fill_vld = 0; fill_idx = '0; fill_is_pf = 0;
        hit_vld = 0; hit_idx = '0;
        mshr_alloc_vld = 0; mshr_alloc_idx = '0; mshr_alloc_pf = 0;
        mshr_free_vld = 0; mshr_free_idx = '0;
        mshr_merge_vld = 0; mshr_merge_idx = '0;
        evict_vld = 0;
    endtask

    task automatic go();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        clear_inputs();
        cfg_interval = 16'd3; cfg_acc_hi = 7'd75; cfg_acc_lo = 7'd40; cfg_late_thr = 7'd10;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports while reset is held
        cmp("R1 reset rpt_vld", int'(rpt_vld), 0);
        cmp("R1 reset total", int'(rpt_total), 0);
        cmp("R1 reset class", int'(rpt_acc_class), 0);
        cmp("R1 reset late class", int'(rpt_late_cls), 0);
        rst_n = 1'b1;
        chk_en = 1'b1;
        go();

        // R4, R3: prefetch fill sets flag, first hit counts, second hit does not
        fill_vld = 1; fill_idx = 11'd3; fill_is_pf = 1; go();
        hit_vld = 1; hit_idx = 11'd3; go();
        hit_vld = 1; hit_idx = 11'd3; go();
        hit_vld = 1; hit_idx = 11'd4; go();
        // R4: demand fill clears a prefetched flag
        fill_vld = 1; fill_idx = 11'd7; fill_is_pf = 1; go();
        fill_vld = 1; fill_idx = 11'd7; fill_is_pf = 0; go();
        hit_vld = 1; hit_idx = 11'd7; go();
        // R5: merge counts once, free removes flag
        mshr_alloc_vld = 1; mshr_alloc_idx = 7'd5; mshr_alloc_pf = 1; go();
        mshr_merge_vld = 1; mshr_merge_idx = 7'd5; go();
        mshr_merge_vld = 1; mshr_merge_idx = 7'd5; go();
        mshr_alloc_vld = 1; mshr_alloc_idx = 7'd6; mshr_alloc_pf = 1; go();
        mshr_free_vld = 1; mshr_free_idx = 7'd6; go();
        mshr_merge_vld = 1; mshr_merge_idx = 7'd6; go();
        // R12: hit and prefetch fill on one block in one cycle; flag stays set
        fill_vld = 1; fill_idx = 11'd9; fill_is_pf = 1; go();
        hit_vld = 1; hit_idx = 11'd9; fill_vld = 1; fill_idx = 11'd9; fill_is_pf = 1; go();
        hit_vld = 1; hit_idx = 11'd9; go();
        // R12: merge and prefetch allocation on one entry in one cycle
        mshr_alloc_vld = 1; mshr_alloc_idx = 7'd8; mshr_alloc_pf = 1; go();
        mshr_merge_vld = 1; mshr_merge_idx = 7'd8; mshr_alloc_vld = 1; mshr_alloc_idx = 7'd8; mshr_alloc_pf = 1; go();
        mshr_merge_vld = 1; mshr_merge_idx = 7'd8; go();
        // R2 and R6: prefetches, then three evictions close the interval
        repeat (4) begin pf_issue = 1; go(); end
        evict_vld = 1; go();
        evict_vld = 1; go();
        evict_vld = 1; pf_issue = 1; go();
        repeat (3) go();
        // R6: interval of 0 acts as 1
        cfg_interval = 16'd0;
        pf_issue = 1; go();
        evict_vld = 1; go();
        go();

        // Randomised mix with narrow index range for collisions
        for (int k = 0; k < 40; k++) begin
            cfg_interval = 16'($urandom_range(1, 12));
            cfg_acc_hi   = 7'($urandom_range(30, 100));
            cfg_acc_lo   = 7'($urandom_range(0, 30));
            cfg_late_thr = 7'($urandom_range(0, 60));
            for (int c = 0; c < 80; c++) begin
                pf_issue       = ($urandom_range(0, 2) == 0);
                fill_vld       = ($urandom_range(0, 1) == 0);
                fill_idx       = 11'($urandom_range(0, 15));
                fill_is_pf     = ($urandom_range(0, 2) != 0);
                hit_vld        = ($urandom_range(0, 1) == 0);
                hit_idx        = 11'($urandom_range(0, 15));
                mshr_alloc_vld = ($urandom_range(0, 2) == 0);
                mshr_alloc_idx = 7'($urandom_range(0, 7));
                mshr_alloc_pf  = ($urandom_range(0, 1) == 0);
                mshr_free_vld  = ($urandom_range(0, 3) == 0);
                mshr_free_idx  = 7'($urandom_range(0, 7));
                mshr_merge_vld = ($urandom_range(0, 1) == 0);
                mshr_merge_idx = 7'($urandom_range(0, 7));
                evict_vld      = ($urandom_range(0, 3) == 0);
                go();
            end
        end

        // R10: saturation of the prefetch total
        cfg_interval = 16'd1;
        for (int c = 0; c < 66000; c++) begin
            pf_issue = 1; go();
        end
        pf_issue = 1; evict_vld = 1; go();
        go();
        for (int c = 0; c < 66000; c++) begin
            pf_issue = 1; go();
        end
        evict_vld = 1; go();
        repeat (3) go();
        finish_run();
    end
endmodule